// File: doc/BRIEF.md
# Shared-Pin Address/Data Bus Splitter

This block sits between the pins of an 8-bit processor and the rest of a system. On those pins the low address byte and the data byte share one set of lines. At the start of each bus operation the shared lines carry the low address byte, and an address-latch strobe is high. The block captures that byte and holds it once the strobe falls. It also holds the high address byte, so the system sees one stable 16-bit address for the whole operation.

While the strobe is low, the shared lines carry data. The block steers that data one of two ways. On a write, the processor's byte goes out on a separate write-data path toward memory or I/O. On a read, the byte returned by memory or I/O goes back onto the processor side. Bidirectional pins are modelled as a value plus an output enable for each direction. A direction that is not enabled stands for a released (high-impedance) line.

The capture path is transparent. While the strobe is high, the address outputs follow the pins within the same cycle. On every rising clock edge with the strobe high, the current pin value is stored, and that stored value is shown while the strobe is low.

Top module: `bus_demux`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), with ale low and rd_n and wr_n high, addr_out is 0000h and both ad_oe and mem_wdata_en are 0.
- R2: While ale is high, addr_out[7:0] equals ad_in and addr_out[15:8] equals hi_addr_in in the same cycle.
- R3: While ale is low, addr_out[7:0] equals the ad_in value sampled at the last rising edge at which ale was high. Changes on ad_in during the data phase do not reach it.
- R4: While ale is low, addr_out[15:8] equals the hi_addr_in value sampled at the last rising edge at which ale was high.
- R5: When ale is low, wr_n is low and rd_n is high (write data phase), mem_wdata equals ad_in, mem_wdata_en is 1 and ad_oe is 0.
- R6: When ale is low, rd_n is low and wr_n is high (read data phase), ad_out equals mem_rdata, ad_oe is 1 and mem_wdata_en is 0.
- R7: In all other cases both enables are 0, and ad_out and mem_wdata are 00h. This covers ale high with either strobe low, both strobes low, and both strobes high. ad_oe and mem_wdata_en are never 1 together.
- R8: The address is 16 bits: every low byte 00h–FFh is captured correctly under high bytes 00h, 5Ah, A5h and FFh, covering 0000h–FFFFh at both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address-latch strobe, high in the address cycle |
| hi_addr_in | input | 8 | High address byte from the processor |
| ad_in | input | 8 | Shared address/data lines as driven by the processor |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mem_rdata | input | 8 | Data returned by memory or I/O on a read |
| addr_out | output | 16 | Demultiplexed address bus |
| ad_out | output | 8 | Read data driven back onto the shared lines |
| ad_oe | output | 1 | Enable for ad_out; 0 means the shared lines are released |
| mem_wdata | output | 8 | Write data toward memory or I/O |
| mem_wdata_en | output | 1 | Enable for mem_wdata |

## Verification
The bench runs full read and write bus operations over every low address byte under four high bytes. In each data phase it puts junk on ad_in and a new value on hi_addr_in. A design that kept its capture path open after the strobe fell would show that junk on the address bus. A design that re-sampled the high byte would show the changed high byte.

The bench also drives ale high together with a strobe, and drives both strobes low. A design that let strobes win over the address cycle, or that enabled both directions at once, would put contention on the data lines. Reset is checked with junk already present on the pins, so a hold register that was not cleared shows up.

// File: rtl/bus_demux_pkg.sv
// Package: shared bus phase type and width constants for the bus splitter.
// Assumes one bus operation at a time and strobes that are active-low.
package bus_demux_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } bus_phase_e;

    // Classify the pins into one phase; the address strobe wins over data strobes.
    function automatic bus_phase_e classify(input logic ale, input logic rd_n, input logic wr_n);
        if (ale)                 return PH_ADDR;
        else if (!rd_n && wr_n)  return PH_READ;
        else if (!wr_n && rd_n)  return PH_WRITE;
        else                     return PH_IDLE;
    endfunction

endpackage

// File: rtl/addr_hold.sv
// Module: transparent-then-hold capture for one address field.
// While open_i is high the output follows d_i in the same cycle, and the value is
// stored on each rising edge. While open_i is low the stored value is shown.
// Assumes d_i is stable around the last edge before open_i falls.
module addr_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] held_q;

    // Store the field while the capture window is open; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (open_i) held_q <= d_i;
    end

    // Pass through while open, present the stored field otherwise.
    always_comb begin
        q_o = open_i ? d_i : held_q;
    end

endmodule

// File: rtl/phase_decode.sv
// Module: decodes the control pins into one bus phase.
// Assumes active-low strobes; conflicting strobes map to idle so nothing drives.
module phase_decode
    import bus_demux_pkg::*;
(
    input  logic       ale,
    input  logic       rd_n,
    input  logic       wr_n,
    output bus_phase_e phase_o
);

    // Map the pin combination onto a phase.
    always_comb begin
        phase_o = classify(ale, rd_n, wr_n);
    end

endmodule

// File: rtl/data_steer.sv
// Module: steers the shared data byte in one direction per phase.
// On a write the processor byte goes toward memory; on a read the memory byte
// goes back to the processor. Disabled paths carry zero.
module data_steer
    import bus_demux_pkg::*;
#(
    parameter int W = 8
) (
    input  bus_phase_e   phase_i,
    input  logic [W-1:0] ad_i,
    input  logic [W-1:0] rdata_i,
    output logic [W-1:0] ad_o,
    output logic         ad_oe_o,
    output logic [W-1:0] wdata_o,
    output logic         wdata_en_o
);

    // Select the driving direction from the phase.
    always_comb begin
        ad_o       = '0;
        ad_oe_o    = 1'b0;
        wdata_o    = '0;
        wdata_en_o = 1'b0;
        unique case (phase_i)
            PH_READ: begin
                ad_o    = rdata_i;
                ad_oe_o = 1'b1;
            end
            PH_WRITE: begin
                wdata_o    = ad_i;
                wdata_en_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bus_demux.sv
// Module: top of the shared-pin address/data bus splitter.
// Captures the low and high address bytes while ale is high and holds them.
// Routes the data byte by strobe. Assumes synchronous, single-operation bus use.
module bus_demux
    import bus_demux_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8,
    localparam int ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [HI_W-1:0]   hi_addr_in,
    input  logic [LO_W-1:0]   ad_in,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [LO_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LO_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [LO_W-1:0]   mem_wdata,
    output logic              mem_wdata_en
);

    bus_phase_e      phase;
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    addr_hold #(.W(LO_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (ale),
        .d_i    (ad_in),
        .q_o    (lo_q)
    );

    addr_hold #(.W(HI_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (ale),
        .d_i    (hi_addr_in),
        .q_o    (hi_q)
    );

    phase_decode u_phase (
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .phase_o (phase)
    );

    data_steer #(.W(LO_W)) u_steer (
        .phase_i    (phase),
        .ad_i       (ad_in),
        .rdata_i    (mem_rdata),
        .ad_o       (ad_out),
        .ad_oe_o    (ad_oe),
        .wdata_o    (mem_wdata),
        .wdata_en_o (mem_wdata_en)
    );

    // Join the two captured fields into the full address.
    always_comb begin
        addr_out = {hi_q, lo_q};
    end

endmodule

// File: rtl/bus_demux_chk.sv
// Module: assertion checker for bus_demux, attached by bind.
// Relates the pins to the address and data outputs over time.
module bus_demux_chk #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ale,
    input logic [HI_W-1:0]      hi_addr_in,
    input logic [LO_W-1:0]      ad_in,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic [LO_W-1:0]      mem_rdata,
    input logic [LO_W+HI_W-1:0] addr_out,
    input logic [LO_W-1:0]      ad_out,
    input logic                 ad_oe,
    input logic [LO_W-1:0]      mem_wdata,
    input logic                 mem_wdata_en
);

    assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (addr_out == {hi_addr_in, ad_in}));

    assert_lo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(rst_n)) |-> (addr_out[LO_W-1:0] == $past(addr_out[LO_W-1:0])));

    assert_hi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(rst_n)) |-> (addr_out[LO_W+HI_W-1:LO_W] == $past(addr_out[LO_W+HI_W-1:LO_W])));

    assert_write_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !wr_n && rd_n) |-> (mem_wdata_en && !ad_oe && mem_wdata == ad_in));

    assert_read_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !rd_n && wr_n) |-> (ad_oe && !mem_wdata_en && ad_out == mem_rdata));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe && mem_wdata_en));

    assert_addr_cycle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (!ad_oe && !mem_wdata_en));

endmodule

bind bus_demux bus_demux_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ale          (ale),
    .hi_addr_in   (hi_addr_in),
    .ad_in        (ad_in),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .mem_rdata    (mem_rdata),
    .addr_out     (addr_out),
    .ad_out       (ad_out),
    .ad_oe        (ad_oe),
    .mem_wdata    (mem_wdata),
    .mem_wdata_en (mem_wdata_en)
);

// File: tb/bus_demux_tb.sv
// Bench: sweeps read and write bus operations over all low bytes and four high bytes.
module bus_demux_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ale;
    logic [7:0]  hi_addr_in;
    logic [7:0]  ad_in;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  mem_rdata;
    logic [15:0] addr_out;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  mem_wdata;
    logic        mem_wdata_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_demux u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ale          (ale),
        .hi_addr_in   (hi_addr_in),
        .ad_in        (ad_in),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .mem_rdata    (mem_rdata),
        .addr_out     (addr_out),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .mem_wdata    (mem_wdata),
        .mem_wdata_en (mem_wdata_en)
    );

    // Record one comparison.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one cycle: sample at the falling edge, then move past the rising edge.
    task automatic to_sample();
        @(negedge clk);
    endtask
    task automatic to_drive();
        @(posedge clk);
        #1;
    endtask

    // Confirm that neither direction drives.
    task automatic check_quiet(input string req);
        check({req, " ad_oe"}, {31'd0, ad_oe}, 32'd0);
        check({req, " wdata_en"}, {31'd0, mem_wdata_en}, 32'd0);
        check({req, " ad_out"}, {24'd0, ad_out}, 32'd0);
        check({req, " wdata"}, {24'd0, mem_wdata}, 32'd0);
    endtask

    // One full operation: address cycle, then two data cycles with junk on the pins.
    task automatic bus_op(input logic [7:0] hi, input logic [7:0] lo, input bit is_write);
        logic [7:0] dat;
        logic [15:0] full;
        dat  = lo ^ hi ^ 8'h3C;
        full = {hi, lo};
        ale = 1'b1; hi_addr_in = hi; ad_in = lo; rd_n = 1'b1; wr_n = 1'b1; mem_rdata = 8'h00;
        to_sample();
        check("R2 addr transparent", {16'd0, addr_out}, {16'd0, full});
        check_quiet("R7 addr cycle");
        to_drive();
        for (int t = 0; t < 2; t++) begin
            ale = 1'b0;
            hi_addr_in = ~hi ^ 8'(t);
            if (is_write) begin
                wr_n = 1'b0; ad_in = dat;
            end else begin
                rd_n = 1'b0; ad_in = ~lo ^ 8'(t * 7); mem_rdata = dat;
            end
            to_sample();
            check("R3 lo held", {24'd0, addr_out[7:0]}, {24'd0, lo});
            check("R4 hi held", {24'd0, addr_out[15:8]}, {24'd0, hi});
            if (is_write) begin
                check("R5 wdata", {24'd0, mem_wdata}, {24'd0, dat});
                check("R5 wdata_en", {31'd0, mem_wdata_en}, 32'd1);
                check("R5 ad_oe off", {31'd0, ad_oe}, 32'd0);
            end else begin
                check("R6 ad_out", {24'd0, ad_out}, {24'd0, dat});
                check("R6 ad_oe", {31'd0, ad_oe}, 32'd1);
                check("R6 wdata_en off", {31'd0, mem_wdata_en}, 32'd0);
            end
            to_drive();
        end
        rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; ale = 1'b1; hi_addr_in = 8'hC3; ad_in = 8'h96;
        rd_n = 1'b1; wr_n = 1'b1; mem_rdata = 8'h00;
        to_drive();
        to_drive();
        ale = 1'b0;
        to_drive();
        rst_n = 1'b1;
        to_sample();
        check("R1 reset addr", {16'd0, addr_out}, 32'd0);
        check_quiet("R1 reset");
        to_drive();

        // R8: full sweep of the low byte under four high bytes, both directions.
        for (int h = 0; h < 4; h++) begin
            logic [7:0] hb;
            hb = (h == 0) ? 8'h00 : (h == 1) ? 8'h5A : (h == 2) ? 8'hA5 : 8'hFF;
            for (int l = 0; l < 256; l++) begin
                bus_op(hb, 8'(l), (l % 2) == 0);
                bus_op(hb, 8'(l), (l % 2) != 0);
            end
        end
        // R8 extremes of the 16-bit space.
        bus_op(8'hFF, 8'hFF, 1'b0);
        to_sample();
        check("R8 top address", {16'd0, addr_out}, 32'h0000FFFF);
        to_drive();
        bus_op(8'h00, 8'h00, 1'b1);
        to_sample();
        check("R8 bottom address", {16'd0, addr_out}, 32'h00000000);
        to_drive();

        // R7: address strobe together with a data strobe.
        ale = 1'b1; ad_in = 8'h11; hi_addr_in = 8'h22; rd_n = 1'b0; mem_rdata = 8'hEE;
        to_sample();
        check_quiet("R7 ale with rd");
        to_drive();
        wr_n = 1'b0; rd_n = 1'b1;
        to_sample();
        check_quiet("R7 ale with wr");
        to_drive();
        // R7: both strobes low with ale low.
        ale = 1'b0; rd_n = 1'b0; wr_n = 1'b0; ad_in = 8'h77;
        to_sample();
        check_quiet("R7 both strobes");
        check("R3 hold under conflict", {16'd0, addr_out}, 32'h00002211);
        to_drive();
        // R7: both strobes high.
        rd_n = 1'b1; wr_n = 1'b1;
        to_sample();
        check_quiet("R7 idle");
        to_drive();

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule